// File: doc/BRIEF.md
# Error Status Register with Rearm

This block keeps the error status of a local interrupt controller in two stages. A hidden pending accumulator gathers every error bit reported since the last software write. A visible register holds what software reads. A software write does not store its data. It publishes the pending bits into the visible register and empties the accumulator. Because the accumulator is then empty again, the write also rearms the error interrupt.

The error interrupt is one-shot. The first error that arrives while the accumulator is empty raises a single-cycle request. The request carries the vector held in the error entry of the vector table, unless that entry is masked. Later errors only add bits until the next write. In the extended register-access mode only zero may be written. A nonzero write there is still discarded as data, and it logs an illegal-register-address error instead.

Top module: `err_status_reg`

## Requirements
- R1: A write copies the pending accumulator, as it stood before that cycle, into the visible register, and the written data is discarded.
- R2: A write clears the pending accumulator, so the next write publishes only errors that arrived after it.
- R3: `rd_data` always shows the visible register, and it changes only in the cycle after a write.
- R4: Error bits on `err_evt` are ORed into the pending accumulator and do not reach the visible register until a write.
- R5: An error event whose bits are all already set in the accumulator raises no interrupt.
- R6: An interrupt fires only for an event that arrives while the accumulator is empty (the armed state). A write rearms it.
- R7: The request `irq_pulse` is high for one cycle, on the clock edge after the qualifying event. `irq_vector` then equals bits 7:0 of `lvt_entry`.
- R8: With `ext_mode` high, a nonzero write sets the illegal-address bit (bit 7) in the accumulator, and that bit counts as an error event. A zero write in extended mode, and any write with `ext_mode` low, logs nothing.
- R9: When bit 16 of `lvt_entry` is set, errors still accumulate but no interrupt is issued.
- R10: When a write and an error event occur in the same cycle, the write publishes and clears first. The event then lands in the empty accumulator as a first error and can fire.
- R11: Reset clears both registers and `irq_pulse`, and leaves the interrupt armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | ERR_W | Error bits reported in this cycle |
| reg_wr | input | 1 | Software write strobe for the register |
| reg_wdata | input | DATA_W | Write data, checked only for zero in extended mode |
| ext_mode | input | 1 | Extended register-access mode select |
| lvt_entry | input | 32 | Error vector-table entry: vector in 7:0, mask in 16 |
| rd_data | output | ERR_W | Visible error status |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with `irq_pulse` |

## Verification
The assertions assume that `err_evt`, `reg_wr`, `reg_wdata`, `ext_mode` and `lvt_entry` are synchronous and settled at each rising edge. They also assume that `lvt_entry` holds steady during the cycle of an event whose vector is wanted. The bench changes every input only on the falling edge and holds it for a whole cycle. It changes the mask and the mode only between scenarios, while no event is driven. It samples the outputs one nanosecond after the rising edge.

// File: rtl/err_status_reg.sv
module err_status_reg #(
  parameter int ERR_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ILL_BIT = 7,
  parameter int MASK_BIT = 16,
  parameter int VEC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ext_mode,
  input  logic [31:0]       lvt_entry,
  output logic [ERR_W-1:0]  rd_data,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);

  localparam logic [ERR_W-1:0] ILL_MASK = ERR_W'(1) << ILL_BIT;

  logic [ERR_W-1:0] pend_q, vis_q;
  logic [ERR_W-1:0] base, evt_all;
  logic             illegal_wr, fire;

  assign illegal_wr = reg_wr && ext_mode && (reg_wdata != '0);
  assign evt_all    = err_evt | (illegal_wr ? ILL_MASK : '0);
  assign base       = reg_wr ? '0 : pend_q;
  assign fire       = (base == '0) && (evt_all != '0) && !lvt_entry[MASK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      vis_q      <= '0;
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      pend_q    <= base | evt_all;
      if (reg_wr) vis_q <= pend_q;
      irq_pulse <= fire;
      if (fire) irq_vector <= lvt_entry[VEC_W-1:0];
    end
  end

  assign rd_data = vis_q;

  AST_WR_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> rd_data == $past(pend_q)); // R1
  AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> pend_q == $past(evt_all)); // R2
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(rd_data)); // R3
  AST_PEND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (pend_q & $past(pend_q)) == $past(pend_q)); // R4
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(reg_wr || pend_q == '0)); // R6
  AST_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(err_evt != '0 || illegal_wr)); // R5
  AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_vector == $past(lvt_entry[VEC_W-1:0])); // R7
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(lvt_entry[MASK_BIT])); // R9

endmodule

// File: tb/tb_err_status_reg.sv
module tb_err_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  err_evt = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        ext_mode = 1'b0;
  logic [31:0] lvt_entry = 32'h0000_0031;
  logic [7:0]  rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int checks = 0, errors = 0;
  logic last_irq;
  logic [7:0] last_vec;

  always #4 clk = ~clk;

  err_status_reg dut (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .ext_mode(ext_mode), .lvt_entry(lvt_entry),
    .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [31:0] wd, input logic [7:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; err_evt = ev;
    @(posedge clk); #1;
    last_irq = irq_pulse; last_vec = irq_vector;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; err_evt = '0;
  endtask

  task automatic t_reset();
    chk("R11 rd_data", rd_data, 0);
    chk("R11 irq", irq_pulse, 0);
  endtask

  task automatic t_basic();
    cyc(0, 0, 8'h05);
    chk("R7 irq first error", last_irq, 1);
    chk("R7 vector", last_vec, 8'h31);
    chk("R4 visible untouched", rd_data, 0);
    cyc(0, 0, 8'h05);
    chk("R5 repeat bits no irq", last_irq, 0);
    cyc(0, 0, 8'h02);
    chk("R6 not armed", last_irq, 0);
    cyc(1, 32'hFF, 0);
    chk("R1 publish, data ignored", rd_data, 8'h07);
    cyc(1, 0, 0);
    chk("R2 cleared", rd_data, 0);
  endtask

  task automatic t_rearm();
    cyc(0, 0, 8'h40);
    chk("R6 rearmed by write", last_irq, 1);
    cyc(1, 0, 0);
    chk("R1 publish", rd_data, 8'h40);
  endtask

  task automatic t_mask();
    lvt_entry = 32'h0001_0031;
    cyc(0, 0, 8'h08);
    chk("R9 masked no irq", last_irq, 0);
    cyc(1, 0, 0);
    chk("R9 still accumulates", rd_data, 8'h08);
    lvt_entry = 32'h0000_0052;
  endtask

  task automatic t_ext();
    ext_mode = 1'b1;
    cyc(1, 32'h12, 0);
    chk("R8 ext nonzero write irq", last_irq, 1);
    chk("R8 vector", last_vec, 8'h52);
    chk("R8 data ignored", rd_data, 0);
    cyc(1, 0, 0);
    chk("R8 illegal bit logged", rd_data, 8'h80);
    cyc(1, 0, 0);
    chk("R8 zero write logs nothing", rd_data, 0);
    ext_mode = 1'b0;
    cyc(1, 32'h12, 0);
    chk("R8 legacy no irq", last_irq, 0);
    cyc(1, 0, 0);
    chk("R8 legacy logs nothing", rd_data, 0);
  endtask

  task automatic t_same();
    cyc(0, 0, 8'h01);
    chk("R6 first error", last_irq, 1);
    cyc(1, 0, 8'h04);
    chk("R10 same cycle fires", last_irq, 1);
    chk("R10 old bits published", rd_data, 8'h01);
    cyc(0, 0, 0);
    chk("R3 no write no change", rd_data, 8'h01);
    chk("R7 pulse one cycle", irq_pulse, 0);
    cyc(1, 0, 0);
    chk("R10 new bit in fresh accumulator", rd_data, 8'h04);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_basic();
        t_rearm();
        t_mask();
        t_ext();
        t_same();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule